// File: doc/BRIEF.md
# Platform Interrupt Controller Core

This block collects a parameterized set of external interrupt sources and distributes them to several hart contexts. A context is one privilege mode on one hardware thread. Each source has a programmable priority, a pending bit and a gateway. The gateway is built as edge style or level style, chosen per source by a parameter. Each context has its own enable mask over the sources, its own priority threshold, one registered interrupt line, and a claim/complete handshake. A claim takes the best eligible source away from the pending set. That source stays in flight until a completion naming it arrives. The gateway accepts no new request from the source while it is in flight.

Software programs priorities, enables and thresholds through a plain word-addressed register port. Writes take effect at the clock edge and reads are combinational. Claim strobes and completion strobes are single-cycle pulses. They are always accepted, so this port has no back-pressure and no ready signal. Source ID 0 is reserved and means "no interrupt".

Top module: `plic_core`

## Requirements
- R1: After reset, all priorities, enables and thresholds read 0, no source is pending or in flight, every irq_o bit is 0 and every claim_id_o is 0.
- R2: The register address is split as {region[7:6], index[5:0]}. Region 0 holds the priority of source index (1..NSRC, PW bits; index 0 reads 0 and ignores writes). Region 1 holds the enable mask of context index, with bit s for source s and bit 0 always reading 0. Region 2 holds the threshold of context index. Region 3 reads the pending set, with bit s for source s. Unused fields read 0.
- R3: A source raises a context's line or is granted to it only when that context's enable bit for the source is set.
- R4: A source is eligible for a context only when its priority is strictly greater than that context's threshold. A priority of 0 is therefore never eligible, and a threshold at the maximum value silences the line.
- R5: Among the eligible sources the highest priority wins. When priorities are equal, the lowest source ID wins.
- R6: A claim pulse on a context loads claim_id_o with that context's winner at the same edge, or with 0 if nothing is eligible. It also clears the winner's pending bit and marks the source as in flight. claim_id_o holds its value until the next claim.
- R7: When several contexts claim in the same cycle, lower-numbered contexts pick first and later ones exclude sources already granted, so no two contexts receive the same nonzero ID.
- R8: A level source is latched as pending while its input is high and it is not in flight. If the input is still high after completion, the source becomes pending again.
- R9: An edge source (EDGE_MASK bit set; by default sources 4 to 7) latches one rising edge as a pending request. Rising edges that arrive while the source is in flight are dropped.
- R10: A completion whose ID names a source that is not in flight has no effect.
- R11: irq_o is a register and reflects a change of pending, enable, priority or threshold one clock after the edge that made the change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_i | input | NSRC | Interrupt inputs, bit s is source s (1..NSRC) |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 8 | Register word address |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register read data (combinational) |
| claim_i | input | NCTX | Claim pulse per context |
| claim_id_o | output | NCTX x ID_W | Last claimed ID per context |
| cmpl_valid_i | input | NCTX | Completion pulse per context |
| cmpl_id_i | input | NCTX x ID_W | Completed source ID per context |
| irq_o | output | NCTX | Registered interrupt line per context |

## Verification
A vector table sweeps single level sources across priority and threshold pairs that sit just above, equal to and below each other. This separates a strict compare from a non-strict one and also exercises the flush path through a lowered threshold. Directed patterns drive two sources at equal priority, which exposes the wrong tie order, and at unequal priority, which exposes a wrong priority order. Held level inputs show whether a source re-arms after completion. Repeated pulses on an edge source show whether in-flight edges are dropped. Simultaneous claims on two contexts, per-context enable masks and a completion of a source that is not in flight are also tried, and each reveals a different faulty grant or gateway path.

// File: rtl/plic_pkg.sv
package plic_pkg;
  localparam int ADDR_W = 8;
  localparam int DATA_W = 32;

  typedef enum logic [1:0] {
    RGN_PRIO    = 2'd0,
    RGN_ENABLE  = 2'd1,
    RGN_THRESH  = 2'd2,
    RGN_PENDING = 2'd3
  } region_e;
endpackage

// File: rtl/plic_gateway.sv
module plic_gateway #(
  parameter bit EDGE = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic src_i,
  input  logic claim_i,
  input  logic cmpl_i,
  output logic pend_o,
  output logic busy_o
);
  logic prev_q;
  logic req;

  generate
    if (EDGE) begin : g_edge
      assign req = src_i & ~prev_q;
    end else begin : g_level
      assign req = src_i;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prev_q <= 1'b0;
      pend_o <= 1'b0;
      busy_o <= 1'b0;
    end else begin
      prev_q <= src_i;
      if (claim_i) begin
        pend_o <= 1'b0;
        busy_o <= 1'b1;
      end else if (busy_o) begin
        if (cmpl_i) busy_o <= 1'b0;
      end else if (req) begin
        pend_o <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/plic_arbiter.sv
module plic_arbiter #(
  parameter int NSRC = 10,
  parameter int PW   = 3,
  parameter int ID_W = 4
) (
  input  logic [NSRC:0]         elig,
  input  logic [NSRC:0][PW-1:0] prio,
  input  logic [PW-1:0]         thresh,
  output logic [ID_W-1:0]       win_id
);
  logic [PW-1:0] best_p;

  always_comb begin
    best_p = thresh;
    win_id = '0;
    for (int s = 1; s <= NSRC; s++) begin
      if (elig[s] && (prio[s] > best_p)) begin
        best_p = prio[s];
        win_id = ID_W'(s);
      end
    end
  end
endmodule

// File: rtl/plic_core.sv
module plic_core #(
  parameter int           NSRC      = 10,
  parameter int           NCTX      = 2,
  parameter int           PW        = 3,
  parameter logic [NSRC:0] EDGE_MASK = 'h0F0,
  localparam int          ID_W      = $clog2(NSRC + 1)
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [NSRC:1]             src_i,
  input  logic                      cfg_we,
  input  logic [7:0]                cfg_addr,
  input  logic [31:0]               cfg_wdata,
  output logic [31:0]               cfg_rdata,
  input  logic [NCTX-1:0]           claim_i,
  output logic [NCTX-1:0][ID_W-1:0] claim_id_o,
  input  logic [NCTX-1:0]           cmpl_valid_i,
  input  logic [NCTX-1:0][ID_W-1:0] cmpl_id_i,
  output logic [NCTX-1:0]           irq_o
);
  import plic_pkg::*;

  logic [NSRC:0][PW-1:0] prio_q;
  logic [NCTX-1:0][NSRC:0] en_q;
  logic [NCTX-1:0][PW-1:0] thr_q;
  logic [NSRC:0] pend, busy, claim_src, cmpl_src;
  logic [NSRC:0] taken [NCTX+1];
  logic [NCTX-1:0][ID_W-1:0] win_id;

  region_e    rgn;
  logic [5:0] idx;
  assign rgn = region_e'(cfg_addr[7:6]);
  assign idx = cfg_addr[5:0];

  // configuration writes
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prio_q <= '0;
      en_q   <= '0;
      thr_q  <= '0;
    end else if (cfg_we) begin
      for (int s = 1; s <= NSRC; s++)
        if (rgn == RGN_PRIO && idx == 6'(s)) prio_q[s] <= cfg_wdata[PW-1:0];
      for (int c = 0; c < NCTX; c++) begin
        if (rgn == RGN_ENABLE && idx == 6'(c)) en_q[c] <= {cfg_wdata[NSRC:1], 1'b0};
        if (rgn == RGN_THRESH && idx == 6'(c)) thr_q[c] <= cfg_wdata[PW-1:0];
      end
    end
  end

  // configuration reads
  always_comb begin
    cfg_rdata = '0;
    case (rgn)
      RGN_PRIO:
        for (int s = 1; s <= NSRC; s++)
          if (idx == 6'(s)) cfg_rdata = DATA_W'(prio_q[s]);
      RGN_ENABLE:
        for (int c = 0; c < NCTX; c++)
          if (idx == 6'(c)) cfg_rdata = DATA_W'(en_q[c]);
      RGN_THRESH:
        for (int c = 0; c < NCTX; c++)
          if (idx == 6'(c)) cfg_rdata = DATA_W'(thr_q[c]);
      default: cfg_rdata = DATA_W'(pend);
    endcase
  end

  // gateways
  assign pend[0] = 1'b0;
  assign busy[0] = 1'b0;
  genvar gs;
  generate
    for (gs = 1; gs <= NSRC; gs++) begin : g_src
      plic_gateway #(.EDGE(EDGE_MASK[gs])) u_gw (
        .clk    (clk),
        .rst_n  (rst_n),
        .src_i  (src_i[gs]),
        .claim_i(claim_src[gs]),
        .cmpl_i (cmpl_src[gs]),
        .pend_o (pend[gs]),
        .busy_o (busy[gs])
      );
    end
  endgenerate

  // completion decode
  always_comb begin
    cmpl_src = '0;
    for (int c = 0; c < NCTX; c++)
      for (int s = 1; s <= NSRC; s++)
        if (cmpl_valid_i[c] && cmpl_id_i[c] == ID_W'(s)) cmpl_src[s] = 1'b1;
  end

  // per-context arbitration, claim chain in context order
  assign taken[0] = '0;
  genvar gc;
  generate
    for (gc = 0; gc < NCTX; gc++) begin : g_ctx
      logic [NSRC:0] grant;

      plic_arbiter #(.NSRC(NSRC), .PW(PW), .ID_W(ID_W)) u_arb (
        .elig  (pend & en_q[gc] & ~taken[gc]),
        .prio  (prio_q),
        .thresh(thr_q[gc]),
        .win_id(win_id[gc])
      );

      always_comb begin
        grant = '0;
        for (int s = 1; s <= NSRC; s++)
          if (claim_i[gc] && win_id[gc] == ID_W'(s)) grant[s] = 1'b1;
      end

      assign taken[gc+1] = taken[gc] | grant;

      always_ff @(posedge clk) begin
        if (!rst_n) begin
          irq_o[gc]      <= 1'b0;
          claim_id_o[gc] <= '0;
        end else begin
          irq_o[gc] <= (win_id[gc] != '0);
          if (claim_i[gc]) claim_id_o[gc] <= win_id[gc];
        end
      end
    end
  endgenerate

  assign claim_src = taken[NCTX];
endmodule

// File: rtl/plic_checker.sv
module plic_checker #(
  parameter int NSRC = 10,
  parameter int NCTX = 2,
  parameter int PW   = 3,
  parameter int ID_W = 4
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic [NSRC:0]             pend,
  input logic [NSRC:0]             busy,
  input logic [NCTX-1:0][PW-1:0]   thr_q,
  input logic [NCTX-1:0]           claim_i,
  input logic [NCTX-1:0][ID_W-1:0] claim_id_o,
  input logic [NCTX-1:0]           irq_o
);
  genvar s, c, d;
  generate
    for (s = 1; s <= NSRC; s++) begin : g_s
      // R8: a source in flight is never pending at the same time
      assert_pend_busy_excl_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !(pend[s] && busy[s]));
    end
    for (c = 0; c < NCTX; c++) begin : g_c
      // R6: a granted ID is in flight after the claim edge
      assert_claim_in_flight_R6: assert property (@(posedge clk) disable iff (!rst_n)
        claim_i[c] |=> (claim_id_o[c] == '0) ||
                       ((int'(claim_id_o[c]) <= NSRC) && busy[claim_id_o[c]]));
      // R4: maximum threshold keeps the line low
      assert_thr_max_silent_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (thr_q[c] == {PW{1'b1}}) |=> !irq_o[c]);
      for (d = c + 1; d < NCTX; d++) begin : g_d
        // R7: simultaneous claims never share a nonzero ID
        assert_claim_distinct_R7: assert property (@(posedge clk) disable iff (!rst_n)
          (claim_i[c] && claim_i[d]) |=>
            (claim_id_o[c] == '0) || (claim_id_o[c] != claim_id_o[d]));
      end
    end
  endgenerate
endmodule

bind plic_core plic_checker #(.NSRC(NSRC), .NCTX(NCTX), .PW(PW), .ID_W(ID_W)) u_plic_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .pend      (pend),
  .busy      (busy),
  .thr_q     (thr_q),
  .claim_i   (claim_i),
  .claim_id_o(claim_id_o),
  .irq_o     (irq_o)
);

// File: tb/test_plic_core.sv
module test_plic_core;
  localparam int NSRC = 10;
  localparam int NCTX = 2;
  localparam int ID_W = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NSRC:1] src_i = '0;
  logic cfg_we = 1'b0;
  logic [7:0] cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;
  logic [NCTX-1:0] claim_i = '0;
  logic [NCTX-1:0][ID_W-1:0] claim_id_o;
  logic [NCTX-1:0] cmpl_valid_i = '0;
  logic [NCTX-1:0][ID_W-1:0] cmpl_id_i = '0;
  logic [NCTX-1:0] irq_o;

  int checks = 0;
  int fails = 0;

  always #4 clk = ~clk;

  plic_core i_plic_core (
    .clk(clk), .rst_n(rst_n), .src_i(src_i),
    .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .claim_i(claim_i), .claim_id_o(claim_id_o),
    .cmpl_valid_i(cmpl_valid_i), .cmpl_id_i(cmpl_id_i), .irq_o(irq_o)
  );

  // vector: {src[3:0], prio[2:0], thresh[2:0], expect_irq}
  localparam logic [10:0] VEC [8] = '{
    {4'd1,  3'd3, 3'd2, 1'b1},
    {4'd2,  3'd3, 3'd3, 1'b0},
    {4'd3,  3'd7, 3'd6, 1'b1},
    {4'd8,  3'd1, 3'd0, 1'b1},
    {4'd9,  3'd4, 3'd5, 1'b0},
    {4'd10, 3'd7, 3'd7, 1'b0},
    {4'd2,  3'd5, 3'd1, 1'b1},
    {4'd8,  3'd2, 3'd2, 1'b0}
  };

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr(input logic [7:0] a, input int d);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    tick();
    cfg_we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output int d);
    cfg_addr = a;
    #1;
    d = int'(cfg_rdata);
  endtask

  task automatic claim(input int c, output int id);
    claim_i[c] = 1'b1;
    tick();
    claim_i[c] = 1'b0;
    id = int'(claim_id_o[c]);
  endtask

  task automatic cmpl(input int c, input int id);
    cmpl_valid_i[c] = 1'b1;
    cmpl_id_i[c] = ID_W'(id);
    tick();
    cmpl_valid_i[c] = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    int v, id, id2;
    @(negedge clk);
    tick(); tick();
    rst_n = 1'b1;
    tick();

    // R1 reset state
    chk("R1 irq", int'(irq_o), 0);
    chk("R1 claim_id0", int'(claim_id_o[0]), 0);
    rd(8'h03, v); chk("R1 prio", v, 0);
    rd(8'h40, v); chk("R1 enable", v, 0);
    rd(8'hC0, v); chk("R1 pending", v, 0);

    // vector table: R4 threshold compare, R6 claim
    for (int k = 0; k < 8; k++) begin
      int s, p, t, e;
      s = int'(VEC[k][10:7]); p = int'(VEC[k][6:4]);
      t = int'(VEC[k][3:1]);  e = int'(VEC[k][0]);
      wr(8'h00 + 8'(s), p);
      wr(8'h80, t);
      wr(8'h40, 1 << s);
      src_i[s] = 1'b1;
      tick(); tick();
      chk("R4 table irq", int'(irq_o[0]), e);
      claim(0, id);
      chk("R6 table claim", id, e ? s : 0);
      if (e == 0) begin
        wr(8'h80, 0);
        tick();
        chk("R4 table irq after lowering threshold", int'(irq_o[0]), 1);
        claim(0, id);
        chk("R6 table flush claim", id, s);
      end
      src_i[s] = 1'b0;
      cmpl(0, s);
      tick(); tick();
      chk("R8 no re-pend after low input", int'(irq_o[0]), 0);
      wr(8'h00 + 8'(s), 0);
      wr(8'h40, 0);
    end

    // R2 readback
    wr(8'h03, 5);
    rd(8'h03, v); chk("R2 prio readback", v, 5);
    rd(8'h00, v); chk("R2 prio index 0", v, 0);
    wr(8'h41, 32'hFFFF_FFFF);
    rd(8'h41, v); chk("R2 enable bit0 zero", v, 32'h7FE);
    wr(8'h81, 6);
    rd(8'h81, v); chk("R2 threshold readback", v, 6);
    wr(8'h41, 0); wr(8'h81, 0); wr(8'h03, 0);

    // R4 priority 0 never eligible, pending still visible
    wr(8'h40, 1 << 1);
    src_i[1] = 1'b1;
    tick(); tick();
    chk("R4 prio0 irq", int'(irq_o[0]), 0);
    claim(0, id); chk("R4 prio0 claim", id, 0);
    src_i[1] = 1'b0;
    rd(8'hC0, v); chk("R8 level latched pending", v, 2);
    wr(8'h01, 2);
    chk("R11 irq not yet updated", int'(irq_o[0]), 0);
    tick();
    chk("R11 irq one cycle later", int'(irq_o[0]), 1);
    claim(0, id); chk("R6 claim latched level", id, 1);
    cmpl(0, 1);
    wr(8'h01, 0);

    // R5 tie goes to lower ID, then higher priority first
    wr(8'h02, 5); wr(8'h03, 5);
    wr(8'h40, (1 << 2) | (1 << 3));
    src_i[2] = 1'b1; src_i[3] = 1'b1;
    tick(); tick();
    claim(0, id); chk("R5 tie lower id", id, 2);
    claim(0, id); chk("R5 tie second", id, 3);
    claim(0, id); chk("R6 empty claim", id, 0);
    chk("R6 claim_id holds", int'(claim_id_o[0]), 0);
    src_i[2] = 1'b0; src_i[3] = 1'b0;
    cmpl(0, 2); cmpl(0, 3);
    wr(8'h02, 3); wr(8'h09, 6);
    wr(8'h40, (1 << 2) | (1 << 9));
    src_i[2] = 1'b1; src_i[9] = 1'b1;
    tick(); tick();
    claim(0, id); chk("R5 higher priority", id, 9);
    claim(0, id); chk("R5 lower priority next", id, 2);
    src_i[2] = 1'b0; src_i[9] = 1'b0;
    cmpl(0, 9); cmpl(0, 2);
    wr(8'h02, 0); wr(8'h03, 0); wr(8'h09, 0); wr(8'h40, 0);

    // R3 per-context enable
    wr(8'h08, 2);
    wr(8'h41, 1 << 8);
    src_i[8] = 1'b1;
    tick(); tick();
    chk("R3 ctx0 masked", int'(irq_o[0]), 0);
    chk("R3 ctx1 enabled", int'(irq_o[1]), 1);
    claim(0, id); chk("R3 ctx0 claim none", id, 0);
    claim(1, id); chk("R3 ctx1 claim", id, 8);
    src_i[8] = 1'b0;
    cmpl(1, 8);

    // R7 simultaneous claims
    wr(8'h09, 4); wr(8'h08, 4);
    wr(8'h40, (1 << 8) | (1 << 9));
    wr(8'h41, (1 << 8) | (1 << 9));
    src_i[8] = 1'b1; src_i[9] = 1'b1;
    tick(); tick();
    claim_i = 2'b11;
    tick();
    claim_i = 2'b00;
    chk("R7 ctx0 gets lower id", int'(claim_id_o[0]), 8);
    chk("R7 ctx1 gets next", int'(claim_id_o[1]), 9);
    src_i[8] = 1'b0; src_i[9] = 1'b0;
    cmpl(0, 8); cmpl(1, 9);
    wr(8'h40, 0); wr(8'h41, 0); wr(8'h08, 0); wr(8'h09, 0);

    // R10 stray completion ignored, R8 re-pend while held high
    wr(8'h0A, 3);
    wr(8'h40, 1 << 10);
    src_i[10] = 1'b1;
    tick(); tick();
    claim(0, id); chk("R6 claim src10", id, 10);
    cmpl(0, 3);
    tick(); tick();
    chk("R10 stray completion ignored", int'(irq_o[0]), 0);
    claim(0, id); chk("R10 still in flight", id, 0);
    cmpl(0, 10);
    tick(); tick();
    chk("R8 re-pend after completion", int'(irq_o[0]), 1);
    claim(0, id); chk("R8 claim again", id, 10);
    src_i[10] = 1'b0;
    cmpl(0, 10);
    wr(8'h0A, 0);

    // R9 edge source
    wr(8'h05, 4);
    wr(8'h40, 1 << 5);
    src_i[5] = 1'b1; tick(); src_i[5] = 1'b0; tick(); tick();
    chk("R9 edge latched", int'(irq_o[0]), 1);
    claim(0, id); chk("R9 edge claim", id, 5);
    src_i[5] = 1'b1; tick(); src_i[5] = 1'b0; tick();
    cmpl(0, 5);
    tick(); tick();
    chk("R9 edge in flight dropped", int'(irq_o[0]), 0);
    claim(0, id2); chk("R9 dropped claim", id2, 0);
    src_i[5] = 1'b1; tick(); src_i[5] = 1'b0; tick(); tick();
    claim(0, id); chk("R9 new edge after completion", id, 5);
    cmpl(0, 5);

    // R4 maximum threshold silences
    src_i[1] = 1'b1; wr(8'h01, 7); wr(8'h40, 1 << 1); wr(8'h80, 7);
    tick(); tick();
    chk("R4 max threshold", int'(irq_o[0]), 0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule